// File: doc/BRIEF.md
# Page State Exception Checker

The block holds a small table with one state per storage page and screens the machine's storage traffic against it. Each cycle it may take a storage access (an instruction fetch or an operand reference, with its address and the length of the issuing instruction), a page-management command with a target address, or both together. It decides whether the access lands on a page that cannot be referenced. It also decides whether a clear command finds its page parked, and whether a state-changing command asks for a move the transition table forbids. It then reports the exception class, whether the operation is nullified or suppressed, the instruction-length value to record, and a 32-bit interruption word carrying the faulting page address.

Each page is in one of four states: live (addressable), linked (connected), parked (disconnected) or gone (deconfigured). A command that completes without an exception moves its page to the command's target state. The operand of a page-management command is never screened as a storage access. Results appear, with a valid strobe, one cycle after the request. Storage itself, interrupt sequencing and event recording are handled elsewhere.

Top module: `page_state_chk`

## Requirements
- R1: After reset every page is live, and `resValid` is low until a request is taken.
- R2: Any cycle with `reqValid` or `cmdValid` high yields exactly one result with `resValid` high on the next cycle. A cycle with neither high yields no result.
- R3: An access whose page is linked or parked reports `excCode` 1 (page access) with `resSuppress` 0 (nullify). An access to a live or gone page reports no exception. The page index is address bits [PAGE_LSB +: log2(NUM_PAGES)], which with the defaults is address bits 14:11.
- R4: On a page-access exception `intWord` holds zeros in bits 31:24, the page part of the faulting address (address bits 23:11) in bits 23:11, and zeros in bits 10:0.
- R5: A page-access exception on an operand reference reports `lenCode` equal to `reqLen`. On an instruction fetch (`reqIsFetch` 1) it reports `lenCode` 2.
- R6: `cmdOp` 5 (clear) on a parked page reports `excCode` 2 (page state), `resSuppress` 1 and `lenCode` 2. On any other page state it reports no exception and leaves the table unchanged.
- R7: The state-changing commands are `cmdOp` 0 attach, 1 retire, 2 detach, 3 map and 4 unmap. With the default table they are legal only as follows: attach from parked or gone, retire from linked or parked, detach from linked, map from linked, and unmap from live. An illegal request reports `excCode` 3 (page transition), `resSuppress` 1 and `lenCode` 2, and leaves the page unchanged.
- R8: A legal state-changing command reports no exception and moves its page to the command's target state: attach to linked, retire to gone, detach to parked, map to live, unmap to linked. Page states are coded live 0, linked 1, parked 2, gone 3. `cmdOp` 6 and 7 report no exception and change nothing.
- R9: The target page of a command is never screened for access. A command aimed at a linked or parked page never reports `excCode` 1.
- R10: When an access and a command arrive together and the access faults, only the page-access exception is reported and the command has no effect. When the access is clean, the command's outcome is reported.
- R11: A result without an exception shows `excCode` 0, `resSuppress` 0, `lenCode` 0 and `intWord` 0. State and transition exceptions also report `intWord` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Storage access present this cycle |
| reqIsFetch | input | 1 | 1 for instruction fetch, 0 for operand reference |
| reqAddr | input | ADDR_W | Access address |
| reqLen | input | 2 | Length code of the issuing instruction (1 to 3) |
| cmdValid | input | 1 | Page-management command present this cycle |
| cmdOp | input | 3 | Command: 0 attach, 1 retire, 2 detach, 3 map, 4 unmap, 5 clear |
| cmdAddr | input | ADDR_W | Address inside the command's target page |
| resValid | output | 1 | Result strobe, one cycle after a request |
| excCode | output | 2 | 0 none, 1 page access, 2 page state, 3 page transition |
| resSuppress | output | 1 | 1 suppress, 0 nullify (meaningful with an exception) |
| lenCode | output | 2 | Instruction-length value to record |
| intWord | output | 32 | Interruption word with the faulting address |

## Verification
The bench builds the block with its defaults: 16 pages, a 24-bit address and page index bits 14:11. With only 16 pages, a pseudo-random stream of accesses and commands revisits the same pages often. It drives every page through all four states and tries every command from every state. Addresses above bit 14 alias onto the same table entries, so the bench also shows that the interruption word keeps the full high address while the table ignores those bits. Paired access-plus-command cycles reach the priority rule of R10.

// File: rtl/page_state_pkg.sv
package page_state_pkg;

  typedef enum logic [1:0] {
    PG_LIVE   = 2'd0,
    PG_LINKED = 2'd1,
    PG_PARKED = 2'd2,
    PG_GONE   = 2'd3
  } pg_state_e;

  typedef enum logic [2:0] {
    CMD_ATTACH = 3'd0,
    CMD_RETIRE = 3'd1,
    CMD_DETACH = 3'd2,
    CMD_MAP    = 3'd3,
    CMD_UNMAP  = 3'd4,
    CMD_CLEAR  = 3'd5
  } pg_cmd_e;

  typedef enum logic [1:0] {
    EXC_NONE  = 2'd0,
    EXC_ACC   = 2'd1,
    EXC_STATE = 2'd2,
    EXC_TRANS = 2'd3
  } exc_e;

  localparam int NUM_STATES = 4;
  localparam int NUM_MOVES  = 5;

  // Strobes from control to datapath
  typedef struct packed {
    logic      take;
    logic      accFault;
    logic      stateFault;
    logic      transFault;
    logic      commit;
    logic [1:0] nextState;
    logic [1:0] len;
  } strobe_t;

  function automatic logic [1:0] moveTarget(input logic [2:0] op);
    case (op)
      3'd0:    moveTarget = PG_LINKED;
      3'd1:    moveTarget = PG_GONE;
      3'd2:    moveTarget = PG_PARKED;
      3'd3:    moveTarget = PG_LIVE;
      default: moveTarget = PG_LINKED;
    endcase
  endfunction

endpackage

// File: rtl/page_state_ctl.sv
module page_state_ctl
  import page_state_pkg::*;
#(
  parameter logic [NUM_STATES*NUM_MOVES-1:0] LEGAL = 20'h1226C
) (
  input  logic       reqValid,
  input  logic       reqIsFetch,
  input  logic [1:0] reqLen,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic [1:0] accState,
  input  logic [1:0] cmdState,
  output strobe_t    strobe
);

  logic       isMove;
  logic       isClear;
  logic       moveLegal;
  logic [4:0] legIdx;
  logic       accBad;

  always_comb begin
    isMove  = (cmdOp <= 3'd4);
    isClear = (cmdOp == CMD_CLEAR);
    legIdx  = {cmdOp, cmdState};
    moveLegal = isMove ? LEGAL[legIdx] : 1'b0;
    accBad  = reqValid && ((accState == PG_LINKED) || (accState == PG_PARKED));

    strobe.take       = reqValid || cmdValid;
    strobe.accFault   = accBad;
    strobe.stateFault = !accBad && cmdValid && isClear && (cmdState == PG_PARKED);
    strobe.transFault = !accBad && cmdValid && isMove && !moveLegal;
    strobe.commit     = !accBad && cmdValid && isMove && moveLegal;
    strobe.nextState  = moveTarget(cmdOp);

    if (accBad)
      strobe.len = reqIsFetch ? 2'd2 : reqLen;
    else if (strobe.stateFault || strobe.transFault)
      strobe.len = 2'd2;
    else
      strobe.len = 2'd0;
  end

endmodule

// File: rtl/page_state_dp.sv
module page_state_dp
  import page_state_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  parameter int ADDR_W    = 24,
  parameter int PAGE_LSB  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic [1:0]        accState,
  output logic [1:0]        cmdState,
  output logic              resValid,
  output logic [1:0]        excCode,
  output logic              resSuppress,
  output logic [1:0]        lenCode,
  output logic [31:0]       intWord
);

  localparam int IDX_W  = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
  localparam int HIGH_W = ADDR_W - PAGE_LSB;
  localparam int PAD_W  = 32 - ADDR_W;

  logic [NUM_PAGES-1:0][1:0] pageTbl;
  logic [IDX_W-1:0] accIdx;
  logic [IDX_W-1:0] cmdIdx;
  logic [31:0]      faultWord;

  assign accIdx   = reqAddr[PAGE_LSB +: IDX_W];
  assign cmdIdx   = cmdAddr[PAGE_LSB +: IDX_W];
  assign accState = pageTbl[accIdx];
  assign cmdState = pageTbl[cmdIdx];
  assign faultWord = {{PAD_W{1'b0}}, reqAddr[ADDR_W-1 -: HIGH_W], {PAGE_LSB{1'b0}}};

  generate
    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          pageTbl[p] <= PG_LIVE;
        else if (strobe.commit && (cmdIdx == IDX_W'(p)))
          pageTbl[p] <= strobe.nextState;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid    <= 1'b0;
      excCode     <= EXC_NONE;
      resSuppress <= 1'b0;
      lenCode     <= 2'd0;
      intWord     <= '0;
    end else begin
      resValid    <= strobe.take;
      resSuppress <= strobe.stateFault || strobe.transFault;
      lenCode     <= strobe.len;
      intWord     <= strobe.accFault ? faultWord : 32'd0;
      if (strobe.accFault)        excCode <= EXC_ACC;
      else if (strobe.stateFault) excCode <= EXC_STATE;
      else if (strobe.transFault) excCode <= EXC_TRANS;
      else                        excCode <= EXC_NONE;
    end
  end

  // R2
  result_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> resValid);
  // R2
  no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.take |=> !resValid);
  // R4
  access_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && excCode == EXC_ACC) |-> (intWord[31:24] == 8'd0 && intWord[10:0] == 11'd0 && !resSuppress));
  // R7
  suppress_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && (excCode == EXC_STATE || excCode == EXC_TRANS)) |-> (resSuppress && lenCode == 2'd2));
  // R8
  table_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(pageTbl));
  // R11
  clean_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && excCode == EXC_NONE) |-> (intWord == 32'd0 && lenCode == 2'd0 && !resSuppress));

endmodule

// File: rtl/page_state_chk.sv
module page_state_chk
  import page_state_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  parameter int ADDR_W    = 24,
  parameter int PAGE_LSB  = 11,
  parameter logic [NUM_STATES*NUM_MOVES-1:0] LEGAL = 20'h1226C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqIsFetch,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqLen,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              resValid,
  output logic [1:0]        excCode,
  output logic              resSuppress,
  output logic [1:0]        lenCode,
  output logic [31:0]       intWord
);

  strobe_t    strobe;
  logic [1:0] accState;
  logic [1:0] cmdState;

  page_state_ctl #(.LEGAL(LEGAL)) u_ctl (
    .reqValid   (reqValid),
    .reqIsFetch (reqIsFetch),
    .reqLen     (reqLen),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .accState   (accState),
    .cmdState   (cmdState),
    .strobe     (strobe)
  );

  page_state_dp #(
    .NUM_PAGES (NUM_PAGES),
    .ADDR_W    (ADDR_W),
    .PAGE_LSB  (PAGE_LSB)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .cmdAddr     (cmdAddr),
    .accState    (accState),
    .cmdState    (cmdState),
    .resValid    (resValid),
    .excCode     (excCode),
    .resSuppress (resSuppress),
    .lenCode     (lenCode),
    .intWord     (intWord)
  );

  // R10
  access_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && cmdValid && (accState == PG_LINKED || accState == PG_PARKED)) |=> (excCode == EXC_ACC));

endmodule

// File: tb/page_state_chk_bench.sv
module page_state_chk_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqIsFetch = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [1:0]  reqLen = '0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = '0;
  logic [23:0] cmdAddr = '0;
  logic        resValid;
  logic [1:0]  excCode;
  logic        resSuppress;
  logic [1:0]  lenCode;
  logic [31:0] intWord;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    int          cyc;
    logic [1:0]  code;
    logic        sup;
    logic [1:0]  len;
    logic [31:0] word;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  logic [1:0] model [16];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  page_state_chk u_page_state_chk (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsFetch(reqIsFetch),
    .reqAddr(reqAddr), .reqLen(reqLen), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .resValid(resValid), .excCode(excCode),
    .resSuppress(resSuppress), .lenCode(lenCode), .intWord(intWord)
  );

  function automatic bit legalM(input int op, input int s);
    case (op)
      0: return (s == 2) || (s == 3);
      1: return (s == 1) || (s == 2);
      2: return s == 1;
      3: return s == 1;
      4: return s == 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] targetM(input int op);
    case (op)
      0: return 2'd1;
      1: return 2'd3;
      2: return 2'd2;
      3: return 2'd0;
      default: return 2'd1;
    endcase
  endfunction

  task automatic issue(input bit a, input bit f, input logic [23:0] ad, input logic [1:0] ln,
                       input bit c, input logic [2:0] op, input logic [23:0] ca, input string tag);
    exp_t e;
    logic [1:0] ps;
    logic [1:0] cs;
    e.code = 2'd0; e.sup = 1'b0; e.len = 2'd0; e.word = 32'd0; e.tag = tag;
    ps = model[ad[14:11]];
    cs = model[ca[14:11]];
    if (a && (ps == 2'd1 || ps == 2'd2)) begin
      e.code = 2'd1;
      e.len  = f ? 2'd2 : ln;
      e.word = {8'h00, ad[23:11], 11'd0};
    end else if (c) begin
      if (op == 3'd5) begin
        if (cs == 2'd2) begin e.code = 2'd2; e.sup = 1'b1; e.len = 2'd2; end
      end else if (op <= 3'd4) begin
        if (legalM(int'(op), int'(cs))) model[ca[14:11]] = targetM(int'(op));
        else begin e.code = 2'd3; e.sup = 1'b1; e.len = 2'd2; end
      end
    end
    @(negedge clk);
    reqValid = a; reqIsFetch = f; reqAddr = ad; reqLen = ln;
    cmdValid = c; cmdOp = op; cmdAddr = ca;
    e.cyc = cyc;
    expQ.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0; cmdValid = 1'b0;
    end
  endtask

  function automatic logic [23:0] pg(input int p);
    return 24'(p) << 11;
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (expQ.size() > 0 && expQ[0].cyc < cyc) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (!resValid || excCode !== e.code || resSuppress !== e.sup ||
            lenCode !== e.len || intWord !== e.word) begin
          errors++;
          $display("FAIL %s: got v=%b code=%0d sup=%b len=%0d word=%h, expected v=1 code=%0d sup=%b len=%0d word=%h",
                   e.tag, resValid, excCode, resSuppress, lenCode, intWord, e.code, e.sup, e.len, e.word);
        end
      end else if (resValid) begin
        checks++; errors++;
        $display("FAIL R2: got unexpected resValid=1, expected 0");
      end
    end
  end

  task automatic finish_run;
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2: got %0d pending results, expected 0", expQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 16; i++) model[i] = 2'd0;
    repeat (3) @(negedge clk);
    // R1: reset state of the result strobe
    checks++;
    if (resValid !== 1'b0) begin
      errors++;
      $display("FAIL R1: got resValid=%b, expected 0", resValid);
    end
    rstN = 1'b1;
    idle(2);

    // R1: every page live: clean accesses everywhere
    for (int p = 0; p < 16; p++) issue(1, p[0], pg(p) | 24'h5, 2'd1, 0, 3'd0, 24'd0, "R1 live after reset");
    // R8: unmap page 1 -> linked
    issue(0, 0, 0, 0, 1, 3'd4, pg(1), "R8 unmap live");
    // R3 R4 R5: operand on linked page, high address bits kept
    issue(1, 0, 24'hA40ABC | pg(1), 2'd3, 0, 3'd0, 0, "R3 R4 R5 operand fault");
    issue(1, 1, pg(1) | 24'h7FF, 2'd1, 0, 3'd0, 0, "R5 fetch fault len");
    // R6: clear on linked page is clean; R9: target not screened
    issue(0, 0, 0, 0, 1, 3'd5, pg(1), "R6 R9 clear linked");
    issue(0, 0, 0, 0, 1, 3'd2, pg(1), "R8 R9 detach linked");
    issue(0, 0, 0, 0, 1, 3'd5, pg(1), "R6 clear parked");
    issue(1, 0, pg(1), 2'd1, 0, 3'd0, 0, "R3 parked access");
    issue(0, 0, 0, 0, 1, 3'd2, pg(1), "R7 detach parked illegal");
    issue(0, 0, 0, 0, 1, 3'd1, pg(1), "R8 retire parked");
    issue(1, 0, pg(1), 2'd2, 0, 3'd0, 0, "R3 gone access clean");
    issue(0, 0, 0, 0, 1, 3'd3, pg(1), "R7 map gone illegal");
    issue(0, 0, 0, 0, 1, 3'd0, pg(1), "R8 attach gone");
    issue(0, 0, 0, 0, 1, 3'd3, pg(1), "R8 map linked");
    issue(0, 0, 0, 0, 1, 3'd6, pg(1), "R8 reserved op");
    // R10: faulting access with command, command dropped
    issue(0, 0, 0, 0, 1, 3'd4, pg(2), "R8 unmap page2");
    issue(1, 0, pg(2), 2'd2, 1, 3'd4, pg(3), "R10 access wins");
    issue(0, 0, 0, 0, 1, 3'd3, pg(3), "R10 page3 still live");
    issue(1, 1, pg(0), 2'd1, 1, 3'd2, pg(2), "R10 clean access, command runs");
    issue(1, 0, pg(2), 2'd3, 0, 3'd0, 0, "R10 page2 parked");
    // R11 aliasing: bits above index map onto same entry
    issue(1, 0, 24'hF80000 | pg(2), 2'd1, 0, 3'd0, 0, "R3 R4 alias fault");
    idle(2);

    // Mixed stream for R3 R5 R6 R7 R8
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op = (lfsr[10:8] > 3'd5) ? 3'd5 : lfsr[10:8];
      case (lfsr[1:0])
        2'd0: issue(1, 0, {4'(lfsr[15:12]), 5'd0, 4'(lfsr[7:4]), 11'(lfsr)}, 2'(lfsr[3:2] | 2'd1), 0, 3'd0, 0, "R3 R5 mix access");
        2'd1: issue(0, 0, 0, 0, 1, op, pg(int'(lfsr[7:4])), "R6 R7 R8 mix command");
        2'd2: issue(1, lfsr[11], pg(int'(lfsr[15:12])), 2'd3, 1, op, pg(int'(lfsr[7:4])), "R10 mix both");
        default: issue(1, 1, pg(int'(lfsr[7:4])), 2'd1, 0, 3'd0, 0, "R5 mix fetch");
      endcase
    end
    idle(3);
    finish_run();
  end

endmodule